// File: doc/BRIEF.md
# One-Shot Millisecond Countdown Timer

This block is a register-driven countdown timer that fires once. Software first writes a delay, counted in milliseconds, into a value register. It then writes anything at all to a separate trigger register, and the countdown starts. When the programmed number of milliseconds has passed, the timer drives a single-cycle interrupt pulse and goes idle. It does not reload.

A prescaler divides the system clock down to a millisecond tick. The divide ratio comes from the clock-frequency parameter. The prescaler restarts on every trigger, so the delay is a whole number of ticks measured from the trigger write.

Several identical copies can sit side by side. Each copy is reached through its own pair of register selects, and the decoding of those selects lies outside the block. The value register keeps its contents after an expiry, so writing the trigger again repeats the last delay.

Top module: `ms_oneshot_timer`

## Requirements
- R1: After reset `irq_o` is low, the timer is idle and the value register holds 0. A trigger written before any value write therefore fires one tick period after the trigger edge.
- R2: A write cycle (`wr_en_i`=1, `val_sel_i`=1) at a clock edge stores `wdata_i[CNT_W-1:0]` (bits 15:0 by default) in the value register. It does not start a countdown.
- R3: A write cycle with `trig_sel_i`=1 starts the countdown, whatever `wdata_i` holds. For a value N≥1, `irq_o` is high in the cycle that follows clock edge N·DIV after the trigger edge, and low before then. DIV is CLK_FREQ_HZ/TICK_FREQ_HZ.
- R4: A value of 0 fires on the first tick, so `irq_o` is high after edge DIV following the trigger. This is the same timing as a value of 1.
- R5: `irq_o` is high for exactly one clock cycle per expiry.
- R6: After an expiry no further pulse occurs until a new trigger is written.
- R7: A trigger written while a countdown runs restarts it from the current value register contents, with the tick phase realigned to the new trigger edge. The earlier countdown never fires.
- R8: A value write during a countdown leaves the running count unchanged. The next trigger uses the new value.
- R9: With `wr_en_i` low, `val_sel_i`, `trig_sel_i` and `wdata_i` have no effect.
- R10: A trigger on the same edge as the expiring tick restarts the count, and that expiry produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| val_sel_i | input | 1 | Selects the delay value register |
| trig_sel_i | input | 1 | Selects the trigger register |
| wdata_i | input | DW | Write data; the low CNT_W bits form the delay |
| irq_o | output | 1 | Single-cycle expiry interrupt pulse |

## Verification
The assertions assume that the two selects reach the block already decoded and synchronous to `clk_i`. They also assume that a write presents either the value select or the trigger select, not both at once. The bench drives every write from the falling clock edge, asserts exactly one select per write, and sets the tick divisor small enough for each delay to complete within the run. The coincident trigger-and-expiry case is produced on purpose, by placing the trigger write on the exact edge where the tick falls.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic val_we;
    logic start;
  } tmr_cmd_t;

  function automatic int unsigned div_ratio(input int unsigned clk_hz, input int unsigned tick_hz);
    return (clk_hz / tick_hz < 1) ? 1 : clk_hz / tick_hz;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             val_sel_i,
  input  logic             trig_sel_i,
  input  logic [DW-1:0]    wdata_i,
  output tmr_pkg::tmr_cmd_t cmd_o,
  output logic [CNT_W-1:0] value_o
);
  logic [CNT_W-1:0] value_q;
  logic             unused_wdata;

  // trigger data and upper bits are don't-care
  assign unused_wdata = ^wdata_i;

  assign cmd_o.val_we = wr_en_i & val_sel_i;
  assign cmd_o.start  = wr_en_i & trig_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          value_q <= '0;
    else if (cmd_o.val_we) value_q <= wdata_i[CNT_W-1:0];
  end

  assign value_o = value_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused_restart;
      assign unused_restart = restart_i;
      assign tick_o = run_i;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      assign tick_o = run_i && !restart_i && (pre_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  pre_q <= '0;
        else if (restart_i || !run_i) pre_q <= '0;
        else if (pre_q == LAST)       pre_q <= '0;
        else                          pre_q <= pre_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             running_o,
  output logic [CNT_W-1:0] remaining_o,
  output logic             fire_o
);
  logic             run_q, fire_q;
  logic [CNT_W-1:0] rem_q;
  logic             last_tick;

  // 0 and 1 both expire on the first tick
  assign last_tick = run_q && tick_i && (rem_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      rem_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= last_tick && !start_i;
      if (start_i) begin
        run_q <= 1'b1;
        rem_q <= load_i;
      end else if (last_tick) begin
        run_q <= 1'b0;
      end else if (run_q && tick_i) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign running_o   = run_q;
  assign remaining_o = rem_q;
  assign fire_o      = fire_q;
endmodule

// File: rtl/ms_oneshot_timer.sv
module ms_oneshot_timer #(
  parameter int unsigned CLK_FREQ_HZ  = 125_000_000,
  parameter int unsigned TICK_FREQ_HZ = 1000,
  parameter int          DW           = 32,
  parameter int          CNT_W        = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          val_sel_i,
  input  logic          trig_sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic          irq_o
);
  localparam int unsigned DIV = tmr_pkg::div_ratio(CLK_FREQ_HZ, TICK_FREQ_HZ);

  tmr_pkg::tmr_cmd_t cmd;
  logic [CNT_W-1:0]  value;
  logic [CNT_W-1:0]  remaining;
  logic              running, tick, start, val_we;

  assign start  = cmd.start;
  assign val_we = cmd.val_we;

  tmr_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .val_sel_i, .trig_sel_i, .wdata_i,
    .cmd_o(cmd), .value_o(value)
  );

  tmr_prescaler #(.DIV(DIV)) u_pre (
    .clk_i, .rst_ni, .run_i(running), .restart_i(start), .tick_o(tick)
  );

  tmr_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .start_i(start), .load_i(value), .tick_i(tick),
    .running_o(running), .remaining_o(remaining), .fire_o(irq_o)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start,
  input logic             val_we,
  input logic             tick,
  input logic             running,
  input logic [CNT_W-1:0] remaining,
  input logic             irq_o
);
  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_oneshot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !running);

  // R3 / R10: a pulse follows a tick that was not overridden by a trigger
  p_fire_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(tick) && !$past(start)));

  p_start_runs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (running && !irq_o));

  p_hold_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !start && !tick) |=> $stable(remaining));

  p_value_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_we && !start && !running) |=> !running);
endmodule

bind ms_oneshot_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start(start), .val_we(val_we),
  .tick(tick), .running(running), .remaining(remaining), .irq_o(irq_o)
);

// File: tb/tb_ms_oneshot_timer.sv
module tb_ms_oneshot_timer;
  localparam int unsigned CLK_HZ  = 16_000;
  localparam int unsigned TICK_HZ = 1000;
  localparam int          DIV     = CLK_HZ / TICK_HZ;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, val_sel_i = 1'b0, trig_sel_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  ms_oneshot_timer #(.CLK_FREQ_HZ(CLK_HZ), .TICK_FREQ_HZ(TICK_HZ), .DW(32), .CNT_W(16)) dut (
    .clk_i, .rst_ni, .wr_en_i, .val_sel_i, .trig_sel_i, .wdata_i, .irq_o
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one write cycle; returns at the falling edge after the sampling edge
  task automatic wr(input logic v, input logic t, input logic [31:0] d, input logic en = 1'b1);
    wr_en_i = en; val_sel_i = v; trig_sel_i = t; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; val_sel_i = 1'b0; trig_sel_i = 1'b0; wdata_i = '0;
  endtask

  task automatic idle(input int n, input string req);
    int hits = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (irq_o) hits++;
    end
    chk(hits == 0, req, "unexpected irq pulses", hits, 0);
  endtask

  task automatic expect_fire(input int n, input string req);
    idle(n - 1, req);
    @(negedge clk_i);
    chk(irq_o == 1'b1, req, "irq at expiry", int'(irq_o), 1);
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R5", "irq one cycle wide", int'(irq_o), 0);
  endtask

  task automatic t_reset;
    chk(irq_o == 1'b0, "R1", "irq in reset", int'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R1", "irq after reset", int'(irq_o), 0);
    wr(1'b0, 1'b1, 32'h0);
    expect_fire(DIV, "R1");
  endtask

  task automatic t_basic;
    wr(1'b1, 1'b0, 32'h0000_0003);
    idle(2 * DIV, "R2");
    wr(1'b0, 1'b1, 32'hDEAD_BEEF);
    expect_fire(3 * DIV, "R3");
    idle(5 * DIV, "R6");
  endtask

  task automatic t_zero_one;
    wr(1'b1, 1'b0, 32'h0);
    wr(1'b0, 1'b1, 32'h1);
    expect_fire(DIV, "R4");
    wr(1'b1, 1'b0, 32'hFFFF_0001);  // upper bits outside the field
    wr(1'b0, 1'b1, 32'h0);
    expect_fire(DIV, "R2");
  endtask

  task automatic t_retrigger;
    wr(1'b1, 1'b0, 32'd4);
    wr(1'b0, 1'b1, 32'h0);
    idle(30, "R7");
    wr(1'b0, 1'b1, 32'h0);
    expect_fire(4 * DIV, "R7");
    idle(2 * DIV, "R7");
  endtask

  task automatic t_value_during;
    wr(1'b1, 1'b0, 32'd2);
    wr(1'b0, 1'b1, 32'h0);
    idle(5, "R8");
    wr(1'b1, 1'b0, 32'd5);
    expect_fire(2 * DIV - 6, "R8");
    wr(1'b0, 1'b1, 32'h0);
    expect_fire(5 * DIV, "R8");
  endtask

  task automatic t_no_enable;
    wr(1'b1, 1'b0, 32'd3);
    wr(1'b0, 1'b1, 32'h0, 1'b0);
    wr(1'b1, 1'b0, 32'd1, 1'b0);
    idle(5 * DIV, "R9");
    wr(1'b0, 1'b1, 32'h0);
    expect_fire(3 * DIV, "R9");
  endtask

  task automatic t_coincide;
    wr(1'b1, 1'b0, 32'd2);
    wr(1'b0, 1'b1, 32'h0);
    idle(2 * DIV - 1, "R10");
    wr(1'b0, 1'b1, 32'h0);  // lands on the expiring tick edge
    expect_fire(2 * DIV, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_basic();
    t_zero_one();
    t_retrigger();
    t_value_during();
    t_no_enable();
    t_coincide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200_000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule